// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits on the host side of a 16-bit parallel flash and turns one high-level request into the sequence of bus cycles the flash needs. A request carries an operation code, a target address and a data word. The controller then writes the unlock and command cycles for that operation on a simple synchronous bus port. After that it either polls for completion, waits out a fixed pause, or reads back identification words. When the operation is finished it returns a single status pulse.

Completion of a program or erase is detected by reading the same address twice in a row and comparing bit 6 of the two results. While the flash is busy that bit flips on every read. A poll budget bounds the wait. After a successful program the word is read once more and compared with the requested data. Each bus cycle takes one clock. A write is a one-cycle strobe with address and data. A read is a one-cycle strobe, and its data is valid on the cycle that follows.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Out of reset, req_ready is 1, rsp_valid is 0, and neither fl_wr nor fl_rd is active.
- R2: A request is taken on a cycle where req_valid and req_ready are both 1. For a valid code, req_ready is 0 on the next cycle and stays 0 until the response. The response is a single-cycle rsp_valid pulse, and req_ready returns to 1 on the cycle after it.
- R3: Operation code 0 (program) writes four cycles on consecutive clocks: 00AAh to 5555h, 0055h to 2AAAh, 00A0h to 5555h, then the request data to the request address. The upper byte of every command cycle is 00h.
- R4: Operation codes 1 (main-array erase), 2 (whole-chip erase) and 3 (boot lockout) write six cycles: 00AAh@5555h, 0055h@2AAAh, 0080h@5555h, 00AAh@5555h, 0055h@2AAAh, then 0030h, 0010h or 0040h respectively to 5555h.
- R5: After a program or erase, reads are issued in back-to-back pairs at the request address. The operation completes when bit 6 matches across the two reads of a pair. An erase then reports status 0 (OK).
- R6: If bit 6 differs in MAX_POLLS consecutive pairs, the controller issues no further reads and reports status 1 (timeout). That is exactly 2*MAX_POLLS poll reads.
- R7: After a program completes, one more read of the target address follows. The status is 0 if the read matches the request data and 2 (verify error) if it does not.
- R8: After the lockout command, no read is issued. The response follows the last write after PAUSE_CYCLES+1 clocks.
- R9: Operation code 4 (identify) writes 00AAh@5555h, 0055h@2AAAh, 0090h@5555h, then reads addresses 0, 1 and 2, then writes 00AAh@5555h, 0055h@2AAAh, 00F0h@5555h. It presents the words read from 0 and 1 on id_mfr and id_dev, and bit 0 of the word read from 2 on id_lock, with status 0.
- R10: Operation codes 5 to 7 cause no bus cycle and give status 3 (bad request) on the cycle after acceptance.
- R11: fl_wr and fl_rd are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_op | input | 3 | Operation code (0 program, 1 main erase, 2 chip erase, 3 lockout, 4 identify) |
| req_addr | input | 16 | Target word address, also the polling address |
| req_data | input | 16 | Word to program |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 0 OK, 1 timeout, 2 verify error, 3 bad request |
| id_mfr | output | 16 | Word read at address 0 by the last identify |
| id_dev | output | 16 | Word read at address 1 by the last identify |
| id_lock | output | 1 | Bit 0 of the word read at address 2 by the last identify |
| fl_wr | output | 1 | Flash write strobe |
| fl_rd | output | 1 | Flash read strobe |
| fl_addr | output | 16 | Flash word address |
| fl_wdata | output | 16 | Flash write data |
| fl_rdata | input | 16 | Flash read data, valid the cycle after fl_rd |

## Verification
A step counter or sequence selector that goes wrong shows up on the bus right away. The very next write strobe carries a wrong address or command byte, or the sequence stops early. A fault in the bit-6 comparator or the poll counter shows up in the read count and the status value as soon as the operation ends. Early exit gives too few reads, and a missed timeout shows up as a hang. A misrouted identification capture or verify compare stays hidden until the response pulse, where the status or the id outputs differ from the words the flash model returned.

// File: rtl/flash_ctrl_pkg.sv
// Shared types and constants for the flash command sequencer.
// Assumes a 16-bit word-addressed flash with a two-step unlock prefix.
package flash_ctrl_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] UNLOCK_A1 = 16'h5555;
    localparam logic [ADDR_W-1:0] UNLOCK_A2 = 16'h2AAA;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_TIMEOUT = 2'd1,
        ST_VERIFY  = 2'd2,
        ST_BADOP   = 2'd3
    } status_e;

    typedef enum logic [2:0] {
        SEQ_PROG,
        SEQ_MAIN,
        SEQ_CHIP,
        SEQ_LOCK,
        SEQ_ID_IN,
        SEQ_ID_OUT
    } seq_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_POLL_A,
        S_POLL_B,
        S_POLL_C,
        S_PAUSE,
        S_VFY_RD,
        S_VFY_CMP,
        S_ID_RD,
        S_ID_CAP
    } ctrl_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_word_t;

    function automatic logic op_is_valid(input logic [2:0] op);
        return op <= 3'd4;
    endfunction

    function automatic seq_e seq_for_op(input logic [2:0] op);
        case (op)
            3'd0:    return SEQ_PROG;
            3'd1:    return SEQ_MAIN;
            3'd2:    return SEQ_CHIP;
            3'd3:    return SEQ_LOCK;
            default: return SEQ_ID_IN;
        endcase
    endfunction

endpackage

// File: rtl/flash_cmd_seq.sv
// Command cycle generator: maps (sequence kind, step index) to the
// address/data of one bus write, and flags the final step.
// Purely combinational; assumes step advances from 0 by one per write.
module flash_cmd_seq
    import flash_ctrl_pkg::*;
(
    input  seq_e              kind,
    input  logic [2:0]        step,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [DATA_W-1:0] tgt_data,
    output bus_word_t         word,
    output logic              last
);

    localparam logic [7:0] PAD = 8'h00;

    // Third command byte, which selects the operation family.
    function automatic logic [7:0] third_byte(input seq_e k);
        case (k)
            SEQ_PROG:   return 8'hA0;
            SEQ_ID_IN:  return 8'h90;
            SEQ_ID_OUT: return 8'hF0;
            default:    return 8'h80;
        endcase
    endfunction

    // Final byte of a six-write sequence.
    function automatic logic [7:0] final_byte(input seq_e k);
        case (k)
            SEQ_CHIP: return 8'h10;
            SEQ_MAIN: return 8'h30;
            default:  return 8'h40;
        endcase
    endfunction

    // Select the write for the current step.
    always_comb begin
        word.addr = UNLOCK_A1;
        word.data = {PAD, 8'hAA};
        last      = 1'b0;
        case (step)
            3'd0: begin
                word.addr = UNLOCK_A1;
                word.data = {PAD, 8'hAA};
            end
            3'd1: begin
                word.addr = UNLOCK_A2;
                word.data = {PAD, 8'h55};
            end
            3'd2: begin
                word.addr = UNLOCK_A1;
                word.data = {PAD, third_byte(kind)};
                last      = (kind == SEQ_ID_IN) || (kind == SEQ_ID_OUT);
            end
            3'd3: begin
                if (kind == SEQ_PROG) begin
                    word.addr = tgt_addr;
                    word.data = tgt_data;
                    last      = 1'b1;
                end else begin
                    word.addr = UNLOCK_A1;
                    word.data = {PAD, 8'hAA};
                end
            end
            3'd4: begin
                word.addr = UNLOCK_A2;
                word.data = {PAD, 8'h55};
            end
            default: begin
                word.addr = UNLOCK_A1;
                word.data = {PAD, final_byte(kind)};
                last      = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/flash_toggle_judge.sv
// Toggle-bit judge: holds bit 6 of the first read of a pair, compares it
// with the second, and counts unsettled pairs against a poll budget.
// Assumes first_vld and second_vld alternate, and clear precedes each op.
module flash_toggle_judge #(
    parameter int MAX_POLLS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic first_vld,
    input  logic second_vld,
    input  logic bit_in,
    output logic settled,
    output logic expired
);

    localparam int CNT_W = $clog2(MAX_POLLS + 1);

    logic             first_q;
    logic [CNT_W-1:0] polls_q;

    assign settled = second_vld && (bit_in == first_q);
    assign expired = second_vld && !settled && (polls_q == CNT_W'(MAX_POLLS - 1));

    // Latch first sample and count pairs that still toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b0;
            polls_q <= '0;
        end else begin
            if (first_vld) first_q <= bit_in;
            if (clear) polls_q <= '0;
            else if (second_vld && !settled) polls_q <= polls_q + 1'b1;
        end
    end

endmodule

// File: rtl/flash_pause_timer.sv
// One-shot pause timer: after start, raises expired once, CYCLES clocks on.
// Assumes start is not re-issued while running.
module flash_pause_timer #(
    parameter int CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);

    localparam int CNT_W = $clog2(CYCLES + 1);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;

    assign expired = run_q && (cnt_q == CNT_W'(CYCLES - 1));

    // Count while running, stop at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (expired) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
// Flash command sequencer top. Takes one request at a time. It writes the
// unlock/command cycles, then polls the toggle bit, pauses, or reads the ID
// words, and ends with a one-cycle status pulse. Assumes fl_rdata is valid on
// the cycle after fl_rd, and one bus cycle per clock.
module flash_cmd_ctrl
    import flash_ctrl_pkg::*;
#(
    parameter int MAX_POLLS    = 1024,
    parameter int PAUSE_CYCLES = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [DATA_W-1:0] id_mfr,
    output logic [DATA_W-1:0] id_dev,
    output logic              id_lock,
    output logic              fl_wr,
    output logic              fl_rd,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    input  logic [DATA_W-1:0] fl_rdata
);

    localparam int POLL_BIT = 6;

    ctrl_state_e       state_q, state_d;
    seq_e              seq_q, seq_d;
    logic [2:0]        step_q, step_d;
    logic [1:0]        id_idx_q, id_idx_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              rsp_valid_q;
    status_e           rsp_status_q, fin_status;
    logic [DATA_W-1:0] id_mfr_q, id_dev_q;
    logic              id_lock_q;

    logic              accept, finish, start_pause;
    logic              first_vld, second_vld;
    logic              settled, expired, pause_done;
    bus_word_t         cmd_word;
    logic              cmd_last;

    flash_cmd_seq u_seq (
        .kind     (seq_q),
        .step     (step_q),
        .tgt_addr (addr_q),
        .tgt_data (data_q),
        .word     (cmd_word),
        .last     (cmd_last)
    );

    flash_toggle_judge #(.MAX_POLLS(MAX_POLLS)) u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .first_vld  (first_vld),
        .second_vld (second_vld),
        .bit_in     (fl_rdata[POLL_BIT]),
        .settled    (settled),
        .expired    (expired)
    );

    flash_pause_timer #(.CYCLES(PAUSE_CYCLES)) u_pause (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_pause),
        .expired (pause_done)
    );

    // Bus strobes and address/data follow the current state.
    always_comb begin
        fl_wr    = (state_q == S_CMD);
        fl_rd    = (state_q == S_POLL_A) || (state_q == S_POLL_B) ||
                   (state_q == S_VFY_RD) || (state_q == S_ID_RD);
        fl_addr  = addr_q;
        fl_wdata = '0;
        if (state_q == S_CMD) begin
            fl_addr  = cmd_word.addr;
            fl_wdata = cmd_word.data;
        end else if (state_q == S_ID_RD) begin
            fl_addr = {{(ADDR_W-2){1'b0}}, id_idx_q};
        end
    end

    // Next-state and control decode.
    always_comb begin
        state_d     = state_q;
        seq_d       = seq_q;
        step_d      = step_q;
        id_idx_d    = id_idx_q;
        accept      = 1'b0;
        finish      = 1'b0;
        fin_status  = ST_OK;
        start_pause = 1'b0;
        first_vld   = 1'b0;
        second_vld  = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (req_valid && req_ready) begin
                    accept = 1'b1;
                    if (op_is_valid(req_op)) begin
                        seq_d   = seq_for_op(req_op);
                        step_d  = 3'd0;
                        state_d = S_CMD;
                    end else begin
                        finish     = 1'b1;
                        fin_status = ST_BADOP;
                    end
                end
            end
            S_CMD: begin
                if (cmd_last) begin
                    step_d = 3'd0;
                    case (seq_q)
                        SEQ_LOCK: begin
                            start_pause = 1'b1;
                            state_d     = S_PAUSE;
                        end
                        SEQ_ID_IN: begin
                            id_idx_d = 2'd0;
                            state_d  = S_ID_RD;
                        end
                        SEQ_ID_OUT: finish = 1'b1;
                        default:    state_d = S_POLL_A;
                    endcase
                end else begin
                    step_d = step_q + 3'd1;
                end
            end
            S_POLL_A: state_d = S_POLL_B;
            S_POLL_B: begin
                first_vld = 1'b1;
                state_d   = S_POLL_C;
            end
            S_POLL_C: begin
                second_vld = 1'b1;
                if (settled) begin
                    if (seq_q == SEQ_PROG) state_d = S_VFY_RD;
                    else finish = 1'b1;
                end else if (expired) begin
                    finish     = 1'b1;
                    fin_status = ST_TIMEOUT;
                end else begin
                    state_d = S_POLL_A;
                end
            end
            S_PAUSE: if (pause_done) finish = 1'b1;
            S_VFY_RD: state_d = S_VFY_CMP;
            S_VFY_CMP: begin
                finish     = 1'b1;
                fin_status = (fl_rdata == data_q) ? ST_OK : ST_VERIFY;
            end
            S_ID_RD: state_d = S_ID_CAP;
            S_ID_CAP: begin
                if (id_idx_q == 2'd2) begin
                    seq_d   = SEQ_ID_OUT;
                    step_d  = 3'd0;
                    state_d = S_CMD;
                end else begin
                    id_idx_d = id_idx_q + 2'd1;
                    state_d  = S_ID_RD;
                end
            end
            default: state_d = S_IDLE;
        endcase
        if (finish) state_d = S_IDLE;
    end

    // State, request latch, response and identification registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= S_IDLE;
            seq_q        <= SEQ_PROG;
            step_q       <= 3'd0;
            id_idx_q     <= 2'd0;
            addr_q       <= '0;
            data_q       <= '0;
            rsp_valid_q  <= 1'b0;
            rsp_status_q <= ST_OK;
            id_mfr_q     <= '0;
            id_dev_q     <= '0;
            id_lock_q    <= 1'b0;
        end else begin
            state_q     <= state_d;
            seq_q       <= seq_d;
            step_q      <= step_d;
            id_idx_q    <= id_idx_d;
            rsp_valid_q <= finish;
            if (finish) rsp_status_q <= fin_status;
            if (accept) begin
                addr_q <= req_addr;
                data_q <= req_data;
            end
            if (state_q == S_ID_CAP) begin
                case (id_idx_q)
                    2'd0:    id_mfr_q  <= fl_rdata;
                    2'd1:    id_dev_q  <= fl_rdata;
                    default: id_lock_q <= fl_rdata[0];
                endcase
            end
        end
    end

    assign req_ready  = (state_q == S_IDLE) && !rsp_valid_q;
    assign rsp_valid  = rsp_valid_q;
    assign rsp_status = rsp_status_q;
    assign id_mfr     = id_mfr_q;
    assign id_dev     = id_dev_q;
    assign id_lock    = id_lock_q;

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
// Protocol checker for flash_cmd_ctrl, attached through bind below.
module flash_cmd_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [2:0]  req_op,
    input logic        rsp_valid,
    input logic [1:0]  rsp_status,
    input logic        fl_wr,
    input logic        fl_rd
);

    // R11
    no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_wr && fl_rd));

    // R1
    idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!fl_wr && !fl_rd));

    // R2
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op <= 3'd4) |=> !req_ready);

    // R2
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2
    ready_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    // R10
    badop_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op > 3'd4) |=> (rsp_valid && rsp_status == 2'd3));

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .fl_wr      (fl_wr),
    .fl_rd      (fl_rd)
);

// File: tb/tb_flash_cmd_ctrl.sv
// Scoreboard bench: the driver queues the expected bus writes, reads and
// responses. A negedge monitor pops and compares them. A small flash model
// answers reads.
module tb_flash_cmd_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_POLLS  = 8;
    localparam int PAUSE      = 20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [2:0]  req_op;
    logic [15:0] req_addr, req_data;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [15:0] id_mfr, id_dev;
    logic        id_lock;
    logic        fl_wr, fl_rd;
    logic [15:0] fl_addr, fl_wdata;
    logic [15:0] fl_rdata = 16'hFFFF;

    flash_cmd_ctrl #(.MAX_POLLS(MAX_POLLS), .PAUSE_CYCLES(PAUSE)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .id_mfr(id_mfr),
        .id_dev(id_dev), .id_lock(id_lock), .fl_wr(fl_wr), .fl_rd(fl_rd),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- flash model ----------------
    logic [15:0] mem [int];
    logic [23:0] hist [0:4] = '{default: 24'h0};
    int          busy = 0;
    int          busy_len = 0;
    bit          tog = 1'b0;
    bit          idm = 1'b0;
    bit          lockm = 1'b0;

    task automatic model_erase(input bit whole);
        int keys[$];
        foreach (mem[k]) if (k >= 32'h2000 || (whole && !lockm)) keys.push_back(k);
        foreach (keys[i]) mem.delete(keys[i]);
    endtask

    task automatic model_write(input logic [15:0] a, input logic [15:0] d);
        bit used = 1'b0;
        if (hist[0] == 24'h5555A0 && hist[1] == 24'h2AAA55 && hist[2] == 24'h5555AA) begin
            if (!(lockm && a < 16'h2000))
                mem[int'(a)] = (mem.exists(int'(a)) ? mem[int'(a)] : 16'hFFFF) & d;
            busy = busy_len;
            used = 1'b1;
        end else if (a == 16'h5555 && hist[0] == 24'h2AAA55 && hist[1] == 24'h5555AA &&
                     hist[2] == 24'h555580 && hist[3] == 24'h2AAA55 && hist[4] == 24'h5555AA) begin
            if (d[7:0] == 8'h40) lockm = 1'b1;
            else if (d[7:0] == 8'h10 || d[7:0] == 8'h30) begin
                model_erase(d[7:0] == 8'h10);
                busy = busy_len;
            end
            used = 1'b1;
        end else if (a == 16'h5555 && hist[0] == 24'h2AAA55 && hist[1] == 24'h5555AA &&
                     d[7:0] == 8'h90) begin
            idm  = 1'b1;
            used = 1'b1;
        end else if (d[7:0] == 8'hF0) begin
            idm  = 1'b0;
            used = 1'b1;
        end
        if (used) hist = '{default: 24'h0};
        else begin
            for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = {a, d[7:0]};
        end
    endtask

    always @(posedge clk) begin
        logic [15:0] v;
        if (busy > 0) busy = busy - 1;
        if (fl_rd === 1'b1) begin
            if (idm) v = (fl_addr == 16'd0) ? 16'h001F : (fl_addr == 16'd1) ? 16'h0087 :
                         (fl_addr == 16'd2) ? {15'd0, lockm} : 16'hFFFF;
            else v = mem.exists(int'(fl_addr)) ? mem[int'(fl_addr)] : 16'hFFFF;
            if (busy > 0) begin
                v[6] = tog;
                tog  = ~tog;
            end
            fl_rdata <= v;
        end
        if (fl_wr === 1'b1) model_write(fl_addr, fl_wdata);
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [1:0]  st;
        bit          is_id;
        logic [15:0] mfr;
        logic [15:0] dev;
        logic        lock;
        string       tag;
    } rsp_t;

    logic [31:0] exp_wr[$];
    string       exp_wr_tag[$];
    logic [15:0] exp_rd[$];
    rsp_t        exp_rsp[$];
    logic [15:0] poll_addr = 16'h0;
    int checks = 0, fails = 0, cyc = 0, nwr = 0, nrd = 0, last_wr_cyc = 0, rsp_cyc = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare bus traffic and responses with the queued expectations.
    always @(negedge clk) begin
        cyc++;
        if (rst_n === 1'b1) begin
            if (fl_wr === 1'b1 || fl_rd === 1'b1)
                check(!(fl_wr && fl_rd), "R11", "rd/wr overlap", {fl_wr, fl_rd}, 0);
            if (fl_wr === 1'b1) begin
                nwr++;
                last_wr_cyc = cyc;
                if (exp_wr.size() == 0) check(1'b0, "R10", "unexpected write", {fl_addr, fl_wdata}, 0);
                else begin
                    logic [31:0] e;
                    string t;
                    e = exp_wr.pop_front();
                    t = exp_wr_tag.pop_front();
                    check({fl_addr, fl_wdata} == e, t, "bus write", {fl_addr, fl_wdata}, e);
                end
            end
            if (fl_rd === 1'b1) begin
                nrd++;
                if (exp_rd.size() > 0) begin
                    logic [15:0] ea;
                    ea = exp_rd.pop_front();
                    check(fl_addr == ea, "R9", "id read address", fl_addr, ea);
                end else check(fl_addr == poll_addr, "R5", "poll read address", fl_addr, poll_addr);
            end
            if (rsp_valid === 1'b1) begin
                rsp_cyc = cyc;
                if (exp_rsp.size() == 0) check(1'b0, "R2", "unexpected response", rsp_status, 0);
                else begin
                    rsp_t r;
                    r = exp_rsp.pop_front();
                    check(rsp_status == r.st, r.tag, "status", rsp_status, r.st);
                    if (r.is_id) begin
                        check(id_mfr == r.mfr, "R9", "id_mfr", id_mfr, r.mfr);
                        check(id_dev == r.dev, "R9", "id_dev", id_dev, r.dev);
                        check(id_lock == r.lock, "R9", "id_lock", id_lock, r.lock);
                    end
                end
            end
        end
    end

    task automatic push_w(input logic [15:0] a, input logic [15:0] d, input string t);
        exp_wr.push_back({a, d});
        exp_wr_tag.push_back(t);
    endtask

    task automatic push_unlock(input logic [7:0] b, input string t);
        push_w(16'h5555, 16'h00AA, t);
        push_w(16'h2AAA, 16'h0055, t);
        push_w(16'h5555, {8'h00, b}, t);
    endtask

    // Driver: queue the expectations, then issue the request and wait for the reply.
    task automatic do_op(input logic [2:0] op, input logic [15:0] a, input logic [15:0] d,
                         input logic [1:0] st, input string tag,
                         input logic [15:0] mfr = 0, input logic [15:0] dev = 0,
                         input logic lock = 0);
        rsp_t r;
        case (op)
            3'd0: begin push_unlock(8'hA0, "R3"); push_w(a, d, "R3"); end
            3'd1: begin push_unlock(8'h80, "R4"); push_unlock(8'h30, "R4"); end
            3'd2: begin push_unlock(8'h80, "R4"); push_unlock(8'h10, "R4"); end
            3'd3: begin push_unlock(8'h80, "R4"); push_unlock(8'h40, "R4"); end
            3'd4: begin
                push_unlock(8'h90, "R9");
                exp_rd.push_back(16'd0);
                exp_rd.push_back(16'd1);
                exp_rd.push_back(16'd2);
                push_unlock(8'hF0, "R9");
            end
            default: ;
        endcase
        poll_addr = a;
        r.st = st; r.is_id = (op == 3'd4); r.mfr = mfr; r.dev = dev; r.lock = lock; r.tag = tag;
        exp_rsp.push_back(r);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (op <= 3'd4) check(req_ready == 1'b0, "R2", "ready after accept", req_ready, 0);
        while (exp_rsp.size() != 0) @(negedge clk);
        @(negedge clk);
        check(req_ready == 1'b1, "R2", "ready after response", req_ready, 1);
        check(exp_wr.size() == 0, tag, "writes left over", exp_wr.size(), 0);
        exp_wr.delete(); exp_wr_tag.delete(); exp_rd.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: actual no response expected response");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int nw0, nr0;
        rst_n = 1'b0; req_valid = 1'b0; req_op = 0; req_addr = 0; req_data = 0;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
        check(rsp_valid == 1'b0, "R1", "reset rsp_valid", rsp_valid, 0);
        check(fl_wr == 1'b0 && fl_rd == 1'b0, "R1", "reset bus idle", {fl_wr, fl_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        busy_len = 10;
        do_op(3'd0, 16'h3000, 16'h1234, 2'd0, "R7");      // program passes verify
        do_op(3'd0, 16'h3000, 16'hFFFF, 2'd2, "R7");      // cannot raise bits: verify error
        busy_len = 15;
        do_op(3'd1, 16'h3000, 16'h0000, 2'd0, "R5");      // main erase completes by toggle
        busy_len = 0;
        do_op(3'd0, 16'h3000, 16'hFFFF, 2'd0, "R7");      // erased word now reads FFFF
        do_op(3'd4, 16'h0000, 16'h0000, 2'd0, "R9", 16'h001F, 16'h0087, 1'b0);

        nr0 = nrd;
        do_op(3'd3, 16'h5555, 16'h0000, 2'd0, "R8");
        check(nrd == nr0, "R8", "reads during pause", nrd - nr0, 0);
        check(rsp_cyc - last_wr_cyc == PAUSE + 1, "R8", "pause length",
              rsp_cyc - last_wr_cyc, PAUSE + 1);
        do_op(3'd4, 16'h0000, 16'h0000, 2'd0, "R9", 16'h001F, 16'h0087, 1'b1);

        busy_len = 3;
        do_op(3'd0, 16'h0100, 16'h0000, 2'd2, "R7");      // locked boot word stays FFFF
        busy_len = 6;
        do_op(3'd2, 16'h4000, 16'h0000, 2'd0, "R5");      // chip erase

        busy_len = 1000000;
        nr0 = nrd;
        do_op(3'd0, 16'h5000, 16'h0000, 2'd1, "R6");
        check(nrd - nr0 == 2 * MAX_POLLS, "R6", "poll reads before timeout",
              nrd - nr0, 2 * MAX_POLLS);
        busy = 0;

        nw0 = nwr; nr0 = nrd;
        do_op(3'd6, 16'h1111, 16'h2222, 2'd3, "R10");
        check(nwr == nw0 && nrd == nr0, "R10", "bus cycles on bad op",
              (nwr - nw0) + (nrd - nr0), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule